// File: doc/BRIEF.md
# Performance Level Sequencer

This block moves a processor between three speed levels. It also switches a secondary power plane. Power-management software gives a 2-bit command together with a strobe. The block decodes the command and then steps the outputs in a safe order: core-voltage select, clock gate, clock-generator profile select and clock-generator reset. The processor clock stays gated and the processor is held for the whole change.

Voltage settling is observed through a core power-good input. Each wait is a parameterized cycle count: a blanking window, a voltage timeout, the clock-generator reset width and a lock wait. A reset stretcher keeps the processor reset active for a fixed number of cycles after power-on, and again after any supply fault. A voltage that never settles is latched as a fault that keeps the processor in reset.

Top module: `perf_level_sequencer`

## Requirements
- R1: After `rst_n` is released, `vsel_high`=1, `prof_sel`=0, `plane_en`=0 and `clk_en`=1. `cpu_rst` stays high for exactly POR_CYC rising edges after the release.
- R2: Speed codes on `cmd_code` settle to these values: code 0 gives `vsel_high`=1 and `prof_sel`=0 (full speed); code 1 gives `vsel_high`=0 and `prof_sel`=1 (medium); code 2 gives `vsel_high`=0 and `prof_sel`=2 (low).
- R3: Code 3 copies `cmd_plane` to `plane_en` on the edge that accepts the strobe. It leaves the speed outputs unchanged and `busy` stays low.
- R4: The command is only taken on an edge where `cmd_stb` is high. Changes on `cmd_code` or `cmd_plane` without a strobe change no output.
- R5: `clk_en` goes low on the edge that accepts a speed change and stays low until the sequence ends. Every change of `vsel_high` or `prof_sel` happens while `clk_en` is low.
- R6: Each profile change is followed at once by a `pll_rst` pulse of PRST_CYC cycles. After the pulse, the clock stays gated for LOCK_CYC further cycles before the next step.
- R7: When the target needs a higher voltage, `vsel_high` rises first. `prof_sel` changes only after at least VBLANK_CYC cycles have passed and `vcore_good` is high. At no time are `prof_sel`=0 and `vsel_high`=0 at once.
- R8: When the target needs a lower voltage, `prof_sel` changes first. `vsel_high` falls after the lock wait, and the clock is ungated only once `vcore_good` is high again.
- R9: `busy` and `cpu_hold` are high from acceptance until the clock is ungated. Strobes seen while busy are ignored. A strobe for the level already in effect changes nothing and leaves `busy` low.
- R10: If `supply_ok` is low on an edge, `cpu_rst` is high after that edge. Once the supply is good again, `cpu_rst` stays high for POR_CYC more edges.
- R11: If `vcore_good` has not returned within VTO_CYC cycles of a voltage step, `fault` and `cpu_rst` go high and stay high until `rst_n`. The clock stays gated and commands are ignored.
- R12: Commands presented while `cpu_rst` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_stb | input | 1 | Command qualifier strobe |
| cmd_code | input | 2 | 0 full, 1 medium, 2 low speed, 3 plane command |
| cmd_plane | input | 1 | Plane state for code 3 (1 on, 0 off) |
| vcore_good | input | 1 | Core supply has reached its selected level |
| supply_ok | input | 1 | All other monitored supplies good |
| vsel_high | output | 1 | 1 selects the high core voltage |
| prof_sel | output | 2 | Clock-generator profile select |
| pll_rst | output | 1 | Clock-generator reset pulse |
| clk_en | output | 1 | Synchronous processor clock gate enable |
| cpu_hold | output | 1 | Holds the processor from executing |
| busy | output | 1 | Speed transition in progress |
| plane_en | output | 1 | Secondary power plane enable |
| cpu_rst | output | 1 | Processor reset |
| fault | output | 1 | Latched voltage-settle timeout |

## Verification
The assertions check on every cycle the invariants of a transition:
- no voltage or profile change while the clock runs;
- reset pulses only while the clock is gated;
- no full-speed profile on the low voltage;
- the hold covers every busy cycle;
- a supply fault asserts reset;
- the timeout fault stays latched.

Only the bench scenarios can show the order of steps and the final state of each level pair. The same holds for the measured reset-pulse and lock-wait lengths, the stretched reset count, the timeout, and the ignored strobes.

// File: rtl/pls_pkg.sv
package pls_pkg;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_GATE  = 3'd1,
    S_VSET  = 3'd2,
    S_PRST  = 3'd3,
    S_LOCK  = 3'd4,
    S_FAULT = 3'd5
  } seq_st_t;

  localparam logic [1:0] CODE_FULL  = 2'd0;
  localparam logic [1:0] CODE_MED   = 2'd1;
  localparam logic [1:0] CODE_LOW   = 2'd2;
  localparam logic [1:0] CODE_PLANE = 2'd3;

  // Only the full-speed profile needs the high core voltage.
  function automatic logic needs_high_v(input logic [1:0] code);
    return code == CODE_FULL;
  endfunction

  // A lower code is a faster level.
  function automatic logic is_raise(input logic [1:0] cur, input logic [1:0] tgt);
    return tgt < cur;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/pls_cmd_decode.sv
module pls_cmd_decode
  import pls_pkg::*;
(
  input  logic       cmd_stb,
  input  logic [1:0] cmd_code,
  input  logic       cmd_plane,
  input  logic       ready,
  input  logic [1:0] cur_prof,
  output logic       spd_go,
  output logic [1:0] spd_tgt,
  output logic       plane_go,
  output logic       plane_val
);
  logic take;

  assign take      = cmd_stb && ready;
  assign spd_tgt   = cmd_code;
  assign spd_go    = take && (cmd_code != CODE_PLANE) && (cmd_code != cur_prof);
  assign plane_go  = take && (cmd_code == CODE_PLANE);
  assign plane_val = cmd_plane;
endmodule

// File: rtl/pls_reset_ctl.sv
module pls_reset_ctl #(
  parameter int POR_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic tmo_fault,
  output logic cpu_rst
);
  localparam int CW = $clog2(POR_CYC + 1);
  localparam logic [CW-1:0] POR_LOAD = CW'(POR_CYC);

  logic [CW-1:0] stretch_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stretch_cnt <= POR_LOAD;
    end else if (!supply_ok) begin
      stretch_cnt <= POR_LOAD;
    end else if (stretch_cnt != '0) begin
      stretch_cnt <= stretch_cnt - 1'b1;
    end
  end

  assign cpu_rst = (stretch_cnt != '0) || tmo_fault;
endmodule

// File: rtl/pls_seq_fsm.sv
module pls_seq_fsm
  import pls_pkg::*;
#(
  parameter int VBLANK_CYC = 4,
  parameter int VTO_CYC    = 40,
  parameter int PRST_CYC   = 3,
  parameter int LOCK_CYC   = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spd_go,
  input  logic [1:0] spd_tgt,
  input  logic       vcore_good,
  output seq_st_t    st,
  output logic       vsel_high,
  output logic [1:0] prof_sel,
  output logic       ev_vstep,
  output logic       ev_pstep
);
  localparam int CNT_MAX = max3(VTO_CYC, PRST_CYC, LOCK_CYC);
  localparam int CW      = $clog2(CNT_MAX + 1);
  localparam logic [CW-1:0] VBL_MIN   = CW'(VBLANK_CYC);
  localparam logic [CW-1:0] VTO_LAST  = CW'(VTO_CYC - 1);
  localparam logic [CW-1:0] PRST_LAST = CW'(PRST_CYC - 1);
  localparam logic [CW-1:0] LOCK_LAST = CW'(LOCK_CYC - 1);

  logic [CW-1:0] cnt;
  logic [1:0]    tgt;
  logic          v_pend;
  logic          up_v;
  logic          v_ok;

  assign up_v = is_raise(prof_sel, tgt) && needs_high_v(tgt) && !vsel_high;
  assign v_ok = (cnt >= VBL_MIN) && vcore_good;

  assign ev_pstep = ((st == S_GATE) && !up_v) ||
                    ((st == S_VSET) && v_ok && (prof_sel != tgt));
  assign ev_vstep = ((st == S_GATE) && up_v) ||
                    ((st == S_LOCK) && (cnt == LOCK_LAST) && v_pend);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      tgt       <= CODE_FULL;
      vsel_high <= 1'b1;
      prof_sel  <= CODE_FULL;
      v_pend    <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          if (spd_go) begin
            tgt <= spd_tgt;
            cnt <= '0;
            st  <= S_GATE;
          end
        end
        S_GATE: begin
          cnt <= '0;
          if (up_v) begin
            vsel_high <= 1'b1;
            st        <= S_VSET;
          end else begin
            prof_sel <= tgt;
            v_pend   <= vsel_high && !needs_high_v(tgt);
            st       <= S_PRST;
          end
        end
        S_VSET: begin
          if (v_ok) begin
            cnt <= '0;
            if (prof_sel != tgt) begin
              prof_sel <= tgt;
              st       <= S_PRST;
            end else begin
              st <= S_IDLE;
            end
          end else if (cnt == VTO_LAST) begin
            st <= S_FAULT;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_PRST: begin
          if (cnt == PRST_LAST) begin
            cnt <= '0;
            st  <= S_LOCK;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_LOCK: begin
          if (cnt == LOCK_LAST) begin
            cnt <= '0;
            if (v_pend) begin
              vsel_high <= 1'b0;
              v_pend    <= 1'b0;
              st        <= S_VSET;
            end else begin
              st <= S_IDLE;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_FAULT: st <= S_FAULT;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/perf_level_sequencer.sv
module perf_level_sequencer
  import pls_pkg::*;
#(
  parameter int POR_CYC    = 16,
  parameter int VBLANK_CYC = 4,
  parameter int VTO_CYC    = 40,
  parameter int PRST_CYC   = 3,
  parameter int LOCK_CYC   = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_stb,
  input  logic [1:0] cmd_code,
  input  logic       cmd_plane,
  input  logic       vcore_good,
  input  logic       supply_ok,
  output logic       vsel_high,
  output logic [1:0] prof_sel,
  output logic       pll_rst,
  output logic       clk_en,
  output logic       cpu_hold,
  output logic       busy,
  output logic       plane_en,
  output logic       cpu_rst,
  output logic       fault
);
  seq_st_t    st;
  logic       spd_go;
  logic [1:0] spd_tgt;
  logic       plane_go;
  logic       plane_val;
  logic       ready;
  logic       ev_vstep;
  logic       ev_pstep;

  assign ready = (st == S_IDLE) && !cpu_rst;

  pls_cmd_decode u_dec (
    .cmd_stb   (cmd_stb),
    .cmd_code  (cmd_code),
    .cmd_plane (cmd_plane),
    .ready     (ready),
    .cur_prof  (prof_sel),
    .spd_go    (spd_go),
    .spd_tgt   (spd_tgt),
    .plane_go  (plane_go),
    .plane_val (plane_val)
  );

  pls_seq_fsm #(
    .VBLANK_CYC (VBLANK_CYC),
    .VTO_CYC    (VTO_CYC),
    .PRST_CYC   (PRST_CYC),
    .LOCK_CYC   (LOCK_CYC)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .spd_go     (spd_go),
    .spd_tgt    (spd_tgt),
    .vcore_good (vcore_good),
    .st         (st),
    .vsel_high  (vsel_high),
    .prof_sel   (prof_sel),
    .ev_vstep   (ev_vstep),
    .ev_pstep   (ev_pstep)
  );

  assign fault = (st == S_FAULT);

  pls_reset_ctl #(
    .POR_CYC (POR_CYC)
  ) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .supply_ok (supply_ok),
    .tmo_fault (fault),
    .cpu_rst   (cpu_rst)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      plane_en <= 1'b0;
    end else if (plane_go) begin
      plane_en <= plane_val;
    end
  end

  assign busy     = (st == S_GATE) || (st == S_VSET) || (st == S_PRST) || (st == S_LOCK);
  assign clk_en   = (st == S_IDLE);
  assign pll_rst  = (st == S_PRST);
  assign cpu_hold = busy || cpu_rst;
endmodule

// File: rtl/pls_checker.sv
module pls_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_stb,
  input logic       supply_ok,
  input logic       vsel_high,
  input logic [1:0] prof_sel,
  input logic       pll_rst,
  input logic       clk_en,
  input logic       cpu_hold,
  input logic       busy,
  input logic       plane_en,
  input logic       cpu_rst,
  input logic       fault,
  input logic       ev_vstep,
  input logic       ev_pstep
);
  p_prof_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(prof_sel) |-> !clk_en);

  p_vsel_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vsel_high) |-> !clk_en);

  p_vstep_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_vstep |=> !clk_en);

  p_pll_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pll_rst |-> !clk_en);

  p_pstep_reset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pstep |=> pll_rst);

  p_full_on_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(prof_sel == 2'd0 && !vsel_high));

  p_busy_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cpu_hold && !clk_en));

  p_supply_rst_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> cpu_rst);

  p_fault_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> (fault && cpu_rst && !clk_en));

  p_plane_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(plane_en) |-> $past(cmd_stb));
endmodule

bind perf_level_sequencer pls_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_stb   (cmd_stb),
  .supply_ok (supply_ok),
  .vsel_high (vsel_high),
  .prof_sel  (prof_sel),
  .pll_rst   (pll_rst),
  .clk_en    (clk_en),
  .cpu_hold  (cpu_hold),
  .busy      (busy),
  .plane_en  (plane_en),
  .cpu_rst   (cpu_rst),
  .fault     (fault),
  .ev_vstep  (ev_vstep),
  .ev_pstep  (ev_pstep)
);

// File: tb/perf_level_sequencer_bench.sv
`timescale 1ns/1ps
module perf_level_sequencer_bench;
  localparam int POR  = 16;
  localparam int VBL  = 4;
  localparam int VTO  = 40;
  localparam int PRST = 3;
  localparam int LOCK = 8;
  localparam int SUP_DLY = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_stb = 1'b0;
  logic [1:0] cmd_code = 2'd0;
  logic cmd_plane = 1'b0;
  logic vcore_good = 1'b1;
  logic supply_ok = 1'b1;
  logic vsel_high, pll_rst, clk_en, cpu_hold, busy, plane_en, cpu_rst, fault;
  logic [1:0] prof_sel;

  always #10 clk = ~clk;

  perf_level_sequencer #(
    .POR_CYC(POR), .VBLANK_CYC(VBL), .VTO_CYC(VTO), .PRST_CYC(PRST), .LOCK_CYC(LOCK)
  ) u_perf_level_sequencer (
    .clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb), .cmd_code(cmd_code),
    .cmd_plane(cmd_plane), .vcore_good(vcore_good), .supply_ok(supply_ok),
    .vsel_high(vsel_high), .prof_sel(prof_sel), .pll_rst(pll_rst), .clk_en(clk_en),
    .cpu_hold(cpu_hold), .busy(busy), .plane_en(plane_en), .cpu_rst(cpu_rst), .fault(fault)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit dead = 0;
  bit tmo_mode = 0;

  typedef struct packed { logic v; logic [1:0] p; logic [1:0] ord; } exp_t;
  exp_t exp_q[$];

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, expv);
    end
  endtask

  // Supply model: a voltage step drops power-good for SUP_DLY samples.
  logic sup_prev_v = 1'b1;
  int   sup_dly = 0;
  always @(negedge clk) begin
    if (rst_n && vsel_high !== sup_prev_v) begin
      vcore_good <= 1'b0;
      sup_dly = SUP_DLY;
    end else if (sup_dly > 0) begin
      sup_dly--;
      if (sup_dly == 0 && !dead) vcore_good <= 1'b1;
    end
    sup_prev_v = vsel_high;
  end

  // Monitor: observes each transition and compares with the scoreboard.
  logic pv = 1'b1;
  logic [1:0] pp = 2'd0;
  logic pbusy = 1'b0;
  int first_kind = 0;
  bit vchg = 0;
  int pll_len = 0;
  int lock_len = 0;
  bit lock_end = 0;
  logic v_at_pll = 1'b1;
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy && !pbusy) begin
        first_kind = 0; vchg = 0; pll_len = 0; lock_len = 0; lock_end = 0;
      end
      if (vsel_high != pv || prof_sel != pp)
        chk(!clk_en, "R5 change with clock running", clk_en, 0);
      if (vsel_high != pv) begin
        vchg = 1;
        if (first_kind == 0) first_kind = 1;
      end
      if (prof_sel != pp && first_kind == 0) first_kind = 2;
      if (pll_rst) begin
        pll_len++;
        v_at_pll = vsel_high;
      end else if (pll_len > 0 && !lock_end) begin
        if (!clk_en && vsel_high == v_at_pll) lock_len++;
        else lock_end = 1;
      end
      if (pbusy && !busy && !tmo_mode) begin
        if (exp_q.size() == 0) begin
          chk(0, "R9 unexpected transition", 1, 0);
        end else begin
          exp_t e;
          int ord;
          e = exp_q.pop_front();
          ord = (first_kind == 1) ? 1 : (vchg ? 2 : 0);
          chk(vsel_high == e.v, "R2 final vsel_high", vsel_high, e.v);
          chk(prof_sel == e.p, "R2 final prof_sel", prof_sel, e.p);
          chk(ord == int'(e.ord), "R7/R8 step order", ord, e.ord);
          chk(pll_len == PRST, "R6 pll_rst width", pll_len, PRST);
          chk(lock_len == LOCK, "R6 lock wait", lock_len, LOCK);
          chk(clk_en && !cpu_hold, "R9 release at end", clk_en, 1);
        end
      end
    end
    pv = vsel_high; pp = prof_sel; pbusy = busy;
  end

  logic [1:0] cur = 2'd0;

  task automatic strobe(input logic [1:0] code, input logic pl);
    cmd_code = code; cmd_plane = pl; cmd_stb = 1'b1;
    @(posedge clk); @(negedge clk);
    cmd_stb = 1'b0;
  endtask

  task automatic run_speed(input logic [1:0] code, input bit poke);
    exp_t e;
    bit hi_now, hi_new;
    logic plane_before;
    hi_now = (cur == 2'd0);
    hi_new = (code == 2'd0);
    plane_before = plane_en;
    if (code != cur) begin
      e.v = hi_new;
      e.p = code;
      e.ord = (hi_new && !hi_now) ? 2'd1 : ((hi_now && !hi_new) ? 2'd2 : 2'd0);
      exp_q.push_back(e);
    end
    strobe(code, 1'b0);
    if (code == cur) begin
      chk(busy == 1'b0, "R9 same-level strobe keeps busy low", busy, 0);
      chk(clk_en == 1'b1, "R9 same-level strobe keeps clock", clk_en, 1);
    end else begin
      chk(busy && cpu_hold && !clk_en, "R5 gate and hold on acceptance", busy, 1);
      if (poke) begin
        repeat (2) @(negedge clk);
        strobe(2'd3, ~plane_before);
        strobe((code == 2'd2) ? 2'd1 : 2'd2, 1'b0);
      end
      for (int i = 0; i < 200 && busy; i++) @(negedge clk);
      if (poke) begin
        chk(plane_en == plane_before, "R9 plane strobe while busy ignored", plane_en, plane_before);
        chk(prof_sel == code, "R9 speed strobe while busy ignored", prof_sel, code);
      end
      repeat (2) @(negedge clk);
      chk(prof_sel == code && busy == 1'b0, "R9 no late action", prof_sel, code);
      cur = code;
    end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(vsel_high == 1'b1, "R1 reset vsel_high", vsel_high, 1);
    chk(prof_sel == 2'd0, "R1 reset prof_sel", prof_sel, 0);
    chk(plane_en == 1'b0, "R1 reset plane_en", plane_en, 0);
    chk(clk_en == 1'b1, "R1 reset clk_en", clk_en, 1);
    n = 0;
    while (cpu_rst && n < 1000) begin @(negedge clk); n++; end
    chk(n == POR, "R1 power-on reset stretch", n, POR);

    run_speed(2'd1, 0);  // lower from full
    run_speed(2'd2, 0);  // profile only
    run_speed(2'd0, 0);  // raise to full
    run_speed(2'd2, 0);  // lower from full to low
    run_speed(2'd1, 0);  // raise, no voltage change
    run_speed(2'd1, 0);  // same level
    run_speed(2'd0, 1);  // raise with strobes while busy

    strobe(2'd3, 1'b1);
    chk(plane_en == 1'b1 && busy == 1'b0, "R3 plane on", plane_en, 1);
    chk(prof_sel == 2'd0 && vsel_high == 1'b1, "R3 speed unchanged", prof_sel, 0);
    strobe(2'd3, 1'b0);
    chk(plane_en == 1'b0, "R3 plane off", plane_en, 0);

    cmd_code = 2'd2; cmd_plane = 1'b1;
    repeat (10) @(negedge clk);
    chk(prof_sel == 2'd0 && busy == 1'b0 && clk_en == 1'b1, "R4 no strobe, speed", prof_sel, 0);
    cmd_code = 2'd3;
    repeat (3) @(negedge clk);
    chk(plane_en == 1'b0, "R4 no strobe, plane", plane_en, 0);

    supply_ok = 1'b0;
    @(negedge clk);
    chk(cpu_rst == 1'b1, "R10 reset on supply fault", cpu_rst, 1);
    strobe(2'd3, 1'b1);
    chk(plane_en == 1'b0, "R12 plane command during reset", plane_en, 0);
    strobe(2'd1, 1'b0);
    chk(busy == 1'b0 && prof_sel == 2'd0, "R12 speed command during reset", prof_sel, 0);
    supply_ok = 1'b1;
    n = 0;
    while (cpu_rst && n < 1000) begin @(negedge clk); n++; end
    chk(n == POR, "R10 reset stretch after recovery", n, POR);

    run_speed(2'd2, 0);

    tmo_mode = 1; dead = 1;
    strobe(2'd0, 1'b0);
    repeat (VTO + 10) @(negedge clk);
    chk(fault == 1'b1, "R11 timeout fault", fault, 1);
    chk(cpu_rst == 1'b1 && clk_en == 1'b0, "R11 reset and gate held", cpu_rst, 1);
    dead = 0;
    repeat (20) @(negedge clk);
    chk(fault == 1'b1 && cpu_rst == 1'b1, "R11 fault sticky", fault, 1);
    strobe(2'd3, 1'b1);
    chk(plane_en == 1'b0, "R11 command ignored in fault", plane_en, 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog all requirements actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule